// File: doc/BRIEF.md
# Eighteen-bit two-way registered bus transceiver

This block joins two 18-bit ports, A and B, with one data path in each direction. Each path has a single storage element that acts as a transparent latch while its latch enable is high. While the enable is low, the same element behaves as a flip-flop that loads on a falling edge of that path's own transfer clock. Each path also has its own output enable. The A-to-B enable is active high and the B-to-A enable is active low.

The block runs on one system clock. It samples the two transfer clocks in that clock and treats a high sample followed by a low sample as a falling edge. Each port comes out as a data bus plus a drive flag. The tri-state pad that uses the flag sits at the chip top level.

Top module: `bus_xcvr18`

## Requirements
- R1: While `ab_le` is 1, `b_out` equals `a_in` in the same cycle, with no clock edge needed.
- R2: While `ab_le` is 0 and the sampled `ab_clk` stays constant at 1 or at 0, the A-to-B storage keeps its value, so `b_out` does not change whatever `a_in` does.
- R3: While `ab_le` is 0, the A-to-B storage loads `a_in` at a system clock edge where the previous `ab_clk` sample was 1 and the current sample is 0. A rising transfer clock (0 then 1) loads nothing.
- R4: `b_drive` is 1 exactly when `ab_oe` is 1 and reset is not asserted. It is 0 when `ab_oe` is 0.
- R5: `a_drive` is 1 exactly when `ba_oe_n` is 0 and reset is not asserted. It is 0 when `ba_oe_n` is 1.
- R6: The B-to-A path follows the rules of R1, R2, R3 and R7, using `b_in`, `ba_le`, `ba_clk` and `a_out`.
- R7: While a latch enable is 1, its storage loads the input at every system clock edge. After the enable falls, the output holds the last value seen while it was high.
- R8: Storage loads whether or not its output enable is active. A value captured while the drive flag is 0 appears on the output once the drive flag returns to 1.
- R9: A synchronous active-high `rst` clears both storage registers and both sampled transfer clocks to 0, and holds `a_drive` and `b_drive` at 0 while it is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Data received on port A |
| b_in | input | 18 | Data received on port B |
| ab_le | input | 1 | A-to-B latch enable, 1 = transparent |
| ab_clk | input | 1 | A-to-B transfer clock, loads on falling edge |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A latch enable, 1 = transparent |
| ba_clk | input | 1 | B-to-A transfer clock, loads on falling edge |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| b_out | output | 18 | Data to drive onto port B |
| b_drive | output | 1 | Drive flag for the port B pad |
| a_out | output | 18 | Data to drive onto port A |
| a_drive | output | 1 | Drive flag for the port A pad |

## Verification
The A-to-B path is driven by a per-cycle table. The table changes `a_in` on every step, so any leak through the storage shows up. It steps through a transparent run, a latch-enable drop, a transfer clock held high and then held low, a rising transfer clock, and a falling one. A held output tells a correct hold apart from a missed hold, and only the falling transfer clock moves the output, which tells edge polarity apart. Directed steps then run the B-to-A path under the opposite enable polarity, capture while the drive flag is off, and apply reset while both enables ask to drive.

// File: rtl/bus_xcvr18.sv
module bus_xcvr18 #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ab_oe,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic         ba_oe_n,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  output logic [W-1:0] a_out,
  output logic         a_drive
);

  logic [W-1:0] ab_q, ba_q;
  logic         ab_clk_d, ba_clk_d;
  logic         ab_fall, ba_fall;

  assign ab_fall = ab_clk_d & ~ab_clk;
  assign ba_fall = ba_clk_d & ~ba_clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      ab_q     <= '0;
      ab_clk_d <= 1'b0;
    end else begin
      ab_clk_d <= ab_clk;
      if (ab_le || ab_fall) ab_q <= a_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ba_q     <= '0;
      ba_clk_d <= 1'b0;
    end else begin
      ba_clk_d <= ba_clk;
      if (ba_le || ba_fall) ba_q <= b_in;
    end
  end

  assign b_out   = ab_le ? a_in : ab_q;
  assign a_out   = ba_le ? b_in : ba_q;
  assign b_drive = ab_oe & ~rst;
  assign a_drive = ~ba_oe_n & ~rst;

  a_r2_ab_hold: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && (ab_clk_d == ab_clk)) |=> $stable(ab_q));
  a_r3_ab_capture: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && ab_clk_d && !ab_clk) |=> (ab_q == $past(a_in)));
  a_r7_ab_track: assert property (@(posedge clk) disable iff (rst)
    ab_le |=> (ab_q == $past(a_in)));
  a_r6_ba_hold: assert property (@(posedge clk) disable iff (rst)
    (!ba_le && (ba_clk_d == ba_clk)) |=> $stable(ba_q));
  a_r6_ba_capture: assert property (@(posedge clk) disable iff (rst)
    (!ba_le && ba_clk_d && !ba_clk) |=> (ba_q == $past(b_in)));
  a_r9_clear: assert property (@(posedge clk)
    rst |=> (ab_q == '0 && ba_q == '0 && !ab_clk_d && !ba_clk_d));

endmodule

// File: tb/test_bus_xcvr18.sv
module test_bus_xcvr18;
  localparam int W = 18;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_le = 1'b0, ab_clk = 1'b0, ab_oe = 1'b0;
  logic ba_le = 1'b0, ba_clk = 1'b0, ba_oe_n = 1'b1;
  logic [W-1:0] b_out, a_out;
  logic b_drive, a_drive;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_xcvr18 #(.W(W)) i_bus_xcvr18 (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .ab_le(ab_le), .ab_clk(ab_clk), .ab_oe(ab_oe),
    .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n),
    .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
  );

  // {le, tclk, oe, a_in[17:0], exp_b[17:0], exp_drive}
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b1, 18'h12345, 18'h12345, 1'b1},
    {1'b1, 1'b0, 1'b1, 18'h2AAAA, 18'h2AAAA, 1'b1},
    {1'b0, 1'b0, 1'b1, 18'h15555, 18'h2AAAA, 1'b1},
    {1'b0, 1'b1, 1'b1, 18'h00FFF, 18'h2AAAA, 1'b1},
    {1'b0, 1'b1, 1'b1, 18'h3F000, 18'h2AAAA, 1'b1},
    {1'b0, 1'b0, 1'b1, 18'h0F0F0, 18'h2AAAA, 1'b1},
    {1'b0, 1'b0, 1'b1, 18'h33333, 18'h0F0F0, 1'b1},
    {1'b0, 1'b0, 1'b0, 18'h11111, 18'h0F0F0, 1'b0},
    {1'b0, 1'b1, 1'b0, 18'h22222, 18'h0F0F0, 1'b0},
    {1'b0, 1'b0, 1'b0, 18'h3C3C3, 18'h0F0F0, 1'b0},
    {1'b0, 1'b0, 1'b1, 18'h00000, 18'h3C3C3, 1'b1},
    {1'b1, 1'b0, 1'b1, 18'h01234, 18'h01234, 1'b1}
  };
  localparam string VTAG [NV] = '{"R1", "R7", "R7", "R3 rise", "R2 high",
    "R3 fall", "R3 R2 low", "R4", "R4", "R8", "R8", "R1"};

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    ab_oe = 1'b1; ba_oe_n = 1'b0;
    step();
    #1;
    check("R9 b_drive in reset", W'(b_drive), '0);
    check("R9 a_drive in reset", W'(a_drive), '0);
    check("R9 b_out cleared", b_out, '0);
    check("R9 a_out cleared", a_out, '0);
    rst = 1'b0;
    ba_oe_n = 1'b1;
    #1;
    check("R4 b_drive on", W'(b_drive), W'(1));
    check("R5 a_drive off", W'(a_drive), '0);

    for (int i = 0; i < NV; i++) begin
      ab_le = VEC[i][39]; ab_clk = VEC[i][38]; ab_oe = VEC[i][37];
      a_in  = VEC[i][36:19];
      #1;
      check(VTAG[i], b_out, VEC[i][18:1]);
      check({VTAG[i], " drive"}, W'(b_drive), W'(VEC[i][0]));
      step();
    end

    ba_oe_n = 1'b0; ba_le = 1'b1; b_in = 18'h2BEEF;
    #1;
    check("R6 transparent", a_out, 18'h2BEEF);
    check("R5 a_drive on", W'(a_drive), W'(1));
    step();
    ba_le = 1'b0; b_in = 18'h10101;
    #1;
    check("R6 latched", a_out, 18'h2BEEF);
    ba_oe_n = 1'b1; ba_clk = 1'b1; b_in = 18'h05050;
    #1;
    check("R5 a_drive off", W'(a_drive), '0);
    step();
    ba_clk = 1'b0; b_in = 18'h3ABCD;
    step();
    b_in = 18'h00001;
    #1;
    check("R6 fall capture", a_out, 18'h3ABCD);
    ba_clk = 1'b1;
    step();
    b_in = 18'h00002;
    step();
    #1;
    check("R6 rise no capture", a_out, 18'h3ABCD);
    ba_oe_n = 1'b0;
    #1;
    check("R8 shown when enabled", a_out, 18'h3ABCD);

    rst = 1'b1; ab_le = 1'b0; ba_le = 1'b0;
    step();
    #1;
    check("R9 b_drive held off", W'(b_drive), '0);
    check("R9 a_drive held off", W'(a_drive), '0);
    check("R9 b storage zero", b_out, '0);
    check("R9 a storage zero", a_out, '0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule